// File: doc/BRIEF.md
# Paged Register Window Decoder

This block is a 32-bit register-bus slave that opens a large register space through a small bus window. The window is 4 KB wide. A control word in that window holds two independent enable flags and a 6-bit page number. Any access whose offset has bits 11:10 both set is steered into paged storage. The paged target is the 16-bit register offset formed by placing the page number above offset bits 9:0. Every other access lands on the directly mapped registers.

Software uses the block in two steps. It first writes the page number into the control word with a read-modify-write, so that the enable flags keep their values. It then issues any number of accesses through the paged window, and each of them uses that page. The page stays in force until the control word is written again. Reads return one cycle after the request on a registered data output, together with a one-cycle valid strobe.

Top module: `paged_csr_decoder`

## Requirements
- R1: After reset, the control word reads zero (page 0, both flags clear), every direct and paged register reads zero, and rd_valid and rd_data are both low.
- R2: A read accepted at a clock edge raises rd_valid for exactly the next cycle, carrying the data as it stood before that edge. A write never raises rd_valid. While rd_valid is low, rd_data is zero. Back-to-back reads return back-to-back results.
- R3: The control word sits at bus offset 0x808. Bits 1:0 are two enable flags and bits 18:13 hold the page number. All other bits are read as zero, and writes to them are discarded. A write of 0xFFFFFFFF reads back as 0x0007E003.
- R4: A bus offset whose bits 11:10 equal 2'b11 (0xC00 to 0xFFF) addresses the paged space at the full offset {page, offset[9:0]}.
- R5: The page number set by a control write applies to every paged access that follows, including accesses made after intervening direct accesses, until the control word is written again.
- R6: Sixteen paged 32-bit registers are implemented at full offsets 0x13F0 to 0x142C. This range crosses from page 4 into page 5. The same window offset under a different page reaches a different register, or no register.
- R7: Eight direct 32-bit registers are implemented at bus offsets 0x000 to 0x01C.
- R8: A read of an unimplemented direct or paged location returns zero. A write to such a location changes no implemented register.
- R9: An access whose offset bits 1:0 are nonzero is misaligned. A misaligned write changes nothing, and a misaligned read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte offset within the bus window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Registered read data, zero when not valid |

## Verification
A wrong page register shows up at the ports through the next paged read. That read returns a value from the wrong register, or zero, one cycle after the request. The same fault also shows up in a read of the control word. A decoder that sends a window offset to the wrong store appears as a wrong value at the read-back of that location. The offsets chosen for the stimulus sit on both sides of the page 4 to page 5 boundary, at the last implemented word, and one word past it. The scoreboard pairs every read with exactly one strobe, so a missing, extra or late rd_valid is caught in the cycle it occurs.

// File: rtl/paged_csr_pkg.sv
package paged_csr_pkg;
   // destination chosen for one bus access
   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_DIRECT = 2'd1,
      TGT_CTRL   = 2'd2,
      TGT_PAGED  = 2'd3
   } tgt_e;
endpackage

// File: rtl/pcsr_decode.sv
module pcsr_decode
   import paged_csr_pkg::*;
#(
   parameter int BUS_AW    = 12,
   parameter int PAGE_W    = 6,
   parameter int CTRL_OFF  = 'h808,
   parameter int DIR_WORDS = 8,
   parameter int PG_BASE   = 'h13F0,
   parameter int PG_WORDS  = 16,
   localparam int LOW_W    = BUS_AW - 2,
   localparam int DIR_IW   = $clog2(DIR_WORDS),
   localparam int PG_IW    = $clog2(PG_WORDS),
   localparam int PGW_W    = PAGE_W + LOW_W - 2
) (
   input  logic [BUS_AW-1:0] addr,
   input  logic [PAGE_W-1:0] page,
   output tgt_e              tgt,
   output logic [DIR_IW-1:0] dir_idx,
   output logic [PG_IW-1:0]  pg_idx
);
   localparam logic [PGW_W-1:0]    PG_BASE_W = PGW_W'(PG_BASE >> 2);
   localparam logic [PGW_W-1:0]    PG_CNT    = PGW_W'(PG_WORDS);
   localparam logic [BUS_AW-3:0]   DIR_CNT   = (BUS_AW-2)'(DIR_WORDS);
   localparam logic [BUS_AW-1:0]   CTRL_A    = BUS_AW'(CTRL_OFF);

   initial begin
      assert (PG_BASE % 4 == 0) else $error("paged base must be word aligned");
      assert (CTRL_OFF % 4 == 0) else $error("control offset must be word aligned");
      assert (CTRL_OFF >= DIR_WORDS * 4) else $error("control word overlaps direct registers");
      assert (DIR_WORDS * 4 <= (3 << LOW_W)) else $error("direct registers reach paged window");
      assert (CTRL_OFF < (3 << LOW_W)) else $error("control word inside paged window");
   end

   logic              aligned;
   logic              in_window;
   logic [PGW_W-1:0]  pg_word;
   logic [PGW_W-1:0]  pg_rel;
   logic [BUS_AW-3:0] dir_word;

   always_comb begin
      aligned   = (addr[1:0] == 2'b00);
      in_window = (addr[BUS_AW-1 -: 2] == 2'b11);
      pg_word   = {page, addr[LOW_W-1:2]};
      pg_rel    = pg_word - PG_BASE_W;
      dir_word  = addr[BUS_AW-1:2];
      dir_idx   = dir_word[DIR_IW-1:0];
      pg_idx    = pg_rel[PG_IW-1:0];
      tgt       = TGT_NONE;
      if (aligned) begin
         if (in_window) begin
            if (pg_word >= PG_BASE_W && pg_rel < PG_CNT)
               tgt = TGT_PAGED;
         end else if (addr == CTRL_A) begin
            tgt = TGT_CTRL;
         end else if (dir_word < DIR_CNT) begin
            tgt = TGT_DIRECT;
         end
      end
   end
endmodule

// File: rtl/pcsr_ctrl_reg.sv
module pcsr_ctrl_reg #(
   parameter int DW       = 32,
   parameter int FLAG_W   = 2,
   parameter int PAGE_W   = 6,
   parameter int PAGE_LSB = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] flag_wdata,
   input  logic [PAGE_W-1:0] page_wdata,
   output logic [PAGE_W-1:0] page,
   output logic [DW-1:0]     rdata
);
   initial begin
      assert (PAGE_LSB >= FLAG_W) else $error("page field overlaps flags");
      assert (PAGE_LSB + PAGE_W <= DW) else $error("page field outside word");
   end

   logic [FLAG_W-1:0] flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         page  <= '0;
      end else if (wr_en) begin
         flags <= flag_wdata;
         page  <= page_wdata;
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[FLAG_W-1:0]          = flags;
      rdata[PAGE_LSB +: PAGE_W]  = page;
   end

   // R5: page only moves on a control write
   p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(page));
endmodule

// File: rtl/pcsr_reg_bank.sv
module pcsr_reg_bank #(
   parameter int WORDS         = 8,
   parameter int DW            = 32,
   parameter bit RESET_STORAGE = 1'b1,
   localparam int IW           = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   initial begin
      assert (WORDS >= 2 && (1 << IW) == WORDS) else $error("bank depth must be a power of two");
   end

   logic [DW-1:0] mem [WORDS];

   generate
      if (RESET_STORAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[idx] <= wdata;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (wr_en) mem[idx] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[idx];

   // R6/R7: a stored word holds the data written to it
   p_bank_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/paged_csr_decoder.sv
module paged_csr_decoder
   import paged_csr_pkg::*;
#(
   parameter int BUS_AW    = 12,
   parameter int DW        = 32,
   parameter int FLAG_W    = 2,
   parameter int PAGE_W    = 6,
   parameter int PAGE_LSB  = 13,
   parameter int CTRL_OFF  = 'h808,
   parameter int DIR_WORDS = 8,
   parameter int PG_BASE   = 'h13F0,
   parameter int PG_WORDS  = 16,
   parameter bit RESET_STORAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_AW-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data
);
   localparam int DIR_IW = $clog2(DIR_WORDS);
   localparam int PG_IW  = $clog2(PG_WORDS);

   initial begin
      assert (BUS_AW >= 4) else $error("bus window too small");
   end

   tgt_e              tgt;
   logic [PAGE_W-1:0] page;
   logic [DIR_IW-1:0] dir_idx;
   logic [PG_IW-1:0]  pg_idx;
   logic [DW-1:0]     dir_rdata, pg_rdata, ctrl_rdata, rd_mux;
   logic              wr_req;

   assign wr_req = req_valid & req_write;

   pcsr_decode #(
      .BUS_AW(BUS_AW), .PAGE_W(PAGE_W), .CTRL_OFF(CTRL_OFF),
      .DIR_WORDS(DIR_WORDS), .PG_BASE(PG_BASE), .PG_WORDS(PG_WORDS)
   ) u_decode (
      .addr(req_addr), .page(page), .tgt(tgt),
      .dir_idx(dir_idx), .pg_idx(pg_idx)
   );

   pcsr_ctrl_reg #(
      .DW(DW), .FLAG_W(FLAG_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_req && tgt == TGT_CTRL),
      .flag_wdata(req_wdata[FLAG_W-1:0]),
      .page_wdata(req_wdata[PAGE_LSB +: PAGE_W]),
      .page(page), .rdata(ctrl_rdata)
   );

   pcsr_reg_bank #(.WORDS(DIR_WORDS), .DW(DW), .RESET_STORAGE(RESET_STORAGE)) u_direct (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_req && tgt == TGT_DIRECT),
      .idx(dir_idx), .wdata(req_wdata), .rdata(dir_rdata)
   );

   pcsr_reg_bank #(.WORDS(PG_WORDS), .DW(DW), .RESET_STORAGE(RESET_STORAGE)) u_paged (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_req && tgt == TGT_PAGED),
      .idx(pg_idx), .wdata(req_wdata), .rdata(pg_rdata)
   );

   always_comb begin
      case (tgt)
         TGT_DIRECT: rd_mux = dir_rdata;
         TGT_CTRL:   rd_mux = ctrl_rdata;
         TGT_PAGED:  rd_mux = pg_rdata;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid & ~req_write;
         rd_data  <= (req_valid & ~req_write) ? rd_mux : '0;
      end
   end

   // R2: writes produce no read strobe
   p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rd_valid);
   // R2: data bus idles at zero
   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);
   // R4: window offsets never reach direct or control storage
   p_window_paged_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[BUS_AW-1 -: 2] == 2'b11) |-> (tgt == TGT_PAGED || tgt == TGT_NONE));
   // R9: misaligned offsets select nothing
   p_misaligned_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[1:0] != 2'b00) |-> tgt == TGT_NONE);
endmodule

// File: tb/paged_csr_decoder_test.sv
module paged_csr_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   paged_csr_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic issue(logic wr, logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_write = 1'b0;
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      issue(1'b1, a, d);
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      issue(1'b0, a, 32'h0);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic set_page(int p, int flags);
      wr(12'h808, (32'(p) << 13) | 32'(flags));
   endtask

   // monitor: one strobe per queued read, in order
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected rd_valid", rd_data, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_valid === 1'b0, "R1 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
      check(rd_data === 32'h0, "R1 rd_data after reset", rd_data, 32'h0);
      rd(12'h808, 32'h0, "R1 control reset");
      rd(12'h000, 32'h0, "R1 direct reset");
      set_page(5, 0);
      rd(12'hC00, 32'h0, "R1 paged reset");
      idle(2);

      // R7 direct registers, back-to-back write then read (R2)
      for (int i = 0; i < 8; i++) wr(12'(i * 4), 32'hD000_0000 + 32'(i));
      for (int i = 0; i < 8; i++) rd(12'(i * 4), 32'hD000_0000 + 32'(i), "R7 direct readback");
      wr(12'h01C, 32'h1234_5678);
      rd(12'h01C, 32'h1234_5678, "R2 read after write");
      idle(2);

      // R8 unimplemented direct
      rd(12'h020, 32'h0, "R8 unimplemented direct read");
      wr(12'h024, 32'hFFFF_FFFF);
      rd(12'h024, 32'h0, "R8 unimplemented direct write");
      rd(12'h400, 32'h0, "R8 unimplemented direct 0x400");
      rd(12'h000, 32'hD000_0000, "R8 stray write left direct intact");

      // R3 control field layout
      wr(12'h808, 32'hFFFF_FFFF);
      rd(12'h808, 32'h0007_E003, "R3 control all-ones");
      set_page(5, 3);
      rd(12'h808, 32'h0000_A003, "R3 page and flags");

      // R4/R6 paged space across the page boundary
      wr(12'hC00, 32'hAAAA_0001);
      wr(12'hC04, 32'hBBBB_0002);
      wr(12'hC2C, 32'hEEEE_000F);
      rd(12'hC2C, 32'hEEEE_000F, "R6 last paged word");
      rd(12'hC30, 32'h0, "R6 one past last paged word");
      set_page(4, 3);
      wr(12'hFF0, 32'hCCCC_0000);
      wr(12'hFFC, 32'hDDDD_0003);
      rd(12'hC00, 32'h0, "R6 same offset other page");
      rd(12'hFF0, 32'hCCCC_0000, "R4 page 4 first word");
      rd(12'hFEC, 32'h0, "R6 below paged base");
      idle(1);

      // R5 page persists across direct accesses
      set_page(5, 3);
      rd(12'h004, 32'hD000_0001, "R5 direct between paged");
      wr(12'h008, 32'h5555_5555);
      rd(12'hC00, 32'hAAAA_0001, "R5 page kept");
      rd(12'hC04, 32'hBBBB_0002, "R5 page kept second");
      rd(12'h808, 32'h0000_A003, "R3 flags kept after paged traffic");

      // R8 write to unimplemented paged location
      set_page(6, 0);
      wr(12'hC00, 32'hDEAD_BEEF);
      rd(12'hC00, 32'h0, "R8 unimplemented paged read");
      set_page(5, 0);
      rd(12'hC00, 32'hAAAA_0001, "R8 paged intact after stray write");

      // R9 misaligned
      wr(12'h001, 32'h9999_9999);
      rd(12'h000, 32'hD000_0000, "R9 misaligned direct write ignored");
      rd(12'h001, 32'h0, "R9 misaligned read zero");
      wr(12'hC01, 32'h9999_9999);
      rd(12'hC00, 32'hAAAA_0001, "R9 misaligned paged write ignored");
      set_page(4, 0);
      rd(12'hFFC, 32'hDDDD_0003, "R4 page 4 last word");
      idle(4);

      check(exp_q.size() == 0, "R2 every read answered", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule